// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of month, month, two-digit year and a 3-bit weekday. A single-cycle pulse on the one-second input advances the count. The carry chain handles 12-hour or 24-hour hour formats, months of 28, 29, 30 or 31 days, and a leap rule that treats every two-digit year divisible by four as a leap year. That rule makes the calendar correct through the end of the 2000s only.

A host reaches the counters through a simple register port. The read side freezes a coherent copy of all seven bytes with one strobe. Individual bytes are then fetched from that frozen copy while the live counters keep running. The write side opens a session and stages bytes into a shadow store, marking each staged field. A valid close loads only the marked fields into the counters in one cycle. A dropped session throws the staged bytes away.

After reset, which stands for a complete loss of power, the counters hold their default values and a fail flag is raised. Time does not advance until the first committed write. That write also clears the flag.

Top module: `bcd_rtc_core`

Byte index map, used by both the read and the write side: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 year, 6 weekday, 7 unused.

## Requirements
- R1: After reset, reading the frozen copy gives seconds 00, minutes 00, hours 0x12 (12-hour format, AM), day 01, month 01, year 00 and weekday 0, and `clk_fail` is 1. While `clk_fail` is 1, ticks are ignored and no field changes.
- R2: Seconds and minutes count in BCD from 00 to 59. Reaching 59 wraps the field to 00 and carries into the next field. A field changes only on an accepted tick or on a commit.
- R3: When hours bit 7 is 1 (24-hour format), bits 5:0 hold BCD 00 to 23. Stepping past 23 gives 00 and carries into the day.
- R4: When hours bit 7 is 0 (12-hour format), bits 4:0 hold BCD 01 to 12 and bit 5 is 1 for PM. Stepping from 11 gives 12 and flips bit 5. Stepping from 12 gives 01. The day carries only when stepping from 11 PM to 12 AM.
- R5: The weekday (index 6, bits 2:0, upper bits read 0) steps 0 through 6 and wraps from 6 to 0 on each day carry.
- R6: Months 04, 06, 09 and 11 end after day 30. Month 02 ends after day 28 or 29. All other months end after day 31. The day then returns to 01 and the month advances. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R7: February has a day 29 exactly when the two-digit year value is divisible by 4, year 00 included.
- R8: A one-cycle `rd_start` copies all live fields into the frozen copy. `rd_data` shows frozen byte `rd_idx` one cycle after `rd_idx` is applied. Index 7 reads 0. The frozen copy does not change until the next `rd_start`.
- R9: Within a session opened by `wr_start`, each `wr_en` stages `wr_data` for field `wr_idx`. A `wr_stop` loads only the staged fields into the counters. Fields that were not staged keep their running values.
- R10: A `wr_abort` discards the session and changes no field. A `wr_en` outside a session is ignored. Closing a session in which no byte was staged has no effect.
- R11: The commit takes one cycle. A tick that arrives in the commit cycle is dropped. The next tick advances from the committed values.
- R12: The first commit clears `clk_fail`, and counting starts from the next tick. The flag stays 0 until the next reset.
- R13: Bytes are stored exactly as written, with no range check. A field that is not at its wrap value steps as follows: if the low nibble is 9, it becomes 0 and the high nibble increments; otherwise the low nibble increments (for example 0x7A steps to 0x7B).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; models total power loss |
| tick_1hz | input | 1 | One-cycle pulse, one per second |
| rd_start | input | 1 | Freeze all live fields into the read copy |
| rd_idx | input | 3 | Byte index to read from the frozen copy |
| rd_data | output | 8 | Registered frozen byte selected by `rd_idx` |
| wr_start | input | 1 | Open a write session and clear staged marks |
| wr_en | input | 1 | Stage one byte in the open session |
| wr_idx | input | 3 | Field index for the staged byte |
| wr_data | input | 8 | Byte value to stage |
| wr_stop | input | 1 | Valid session end; commit the staged fields |
| wr_abort | input | 1 | Abandon the session and discard staged bytes |
| clk_fail | output | 1 | Set by reset, cleared by the first commit |

## Verification
On every cycle the bound checker confirms that the counters freeze while the fail flag is up and stay still without a tick or commit. It also checks that seconds wrap from 59 to 00, that the frozen copy moves only on a capture strobe and then matches the live seconds, that a commit overrides a coincident tick, and that the fail flag drops on a commit and never returns. Only the bench scenarios can show the deeper carry chain: 12-hour PM flips, month-length and leap-year ends, the weekday wrap, the year wrap, and the effect of aborted or empty sessions. These depend on multi-field setups and on values observed through the read port over several cycles.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W    = 8;
  localparam int FIELD_CNT = 7;

  localparam int IX_SEC   = 0;
  localparam int IX_MIN   = 1;
  localparam int IX_HOUR  = 2;
  localparam int IX_DATE  = 3;
  localparam int IX_MONTH = 4;
  localparam int IX_YEAR  = 5;
  localparam int IX_DOW   = 6;

  typedef logic [BYTE_W-1:0] bcd_byte_t;

  // plain BCD step without range checking (low nibble 9 carries)
  function automatic bcd_byte_t bcd_inc(input bcd_byte_t v);
    if (v[3:0] == 4'h9) bcd_inc = {v[7:4] + 4'h1, 4'h0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'h1};
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic is_leap(input bcd_byte_t y);
    if (y[4]) is_leap = (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    else      is_leap = (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic bcd_byte_t month_end(input bcd_byte_t m, input bcd_byte_t y);
    case (m)
      8'h02:                      month_end = is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
      default:                    month_end = 8'h31;
    endcase
  endfunction

  // returns {day_carry, next_hour_byte}; bit7 selects 24-hour format
  function automatic logic [BYTE_W:0] hour_inc(input bcd_byte_t h);
    bcd_byte_t b;
    bcd_byte_t t;
    logic      cy;
    b  = h;
    cy = 1'b0;
    if (h[7]) begin
      if (h[5:0] == 6'h23) begin
        b[5:0] = 6'h00;
        cy     = 1'b1;
      end else begin
        t      = bcd_inc({2'b00, h[5:0]});
        b[5:0] = t[5:0];
      end
    end else begin
      if (h[4:0] == 5'h12) begin
        b[4:0] = 5'h01;
      end else if (h[4:0] == 5'h11) begin
        b[4:0] = 5'h12;
        b[5]   = ~h[5];
        cy     = h[5];
      end else begin
        t      = bcd_inc({3'b000, h[4:0]});
        b[4:0] = t[4:0];
      end
    end
    return {cy, b};
  endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cal_pkg::*;
#(
  parameter int        DOW_W     = 3,
  parameter int        DOW_LAST  = 6,
  parameter bcd_byte_t RST_HOUR  = 8'h12,
  parameter bcd_byte_t RST_DATE  = 8'h01,
  parameter bcd_byte_t RST_MONTH = 8'h01,
  parameter bcd_byte_t RST_YEAR  = 8'h00
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              tick,
  input  logic                              load,
  input  logic [FIELD_CNT-1:0]              load_mask,
  input  logic [FIELD_CNT-1:0][BYTE_W-1:0]  load_bytes,
  output logic [FIELD_CNT-1:0][BYTE_W-1:0]  live,
  output logic                              fail
);

  localparam logic [FIELD_CNT-1:0][BYTE_W-1:0] RST_VALS =
    {8'h00, RST_YEAR, RST_MONTH, RST_DATE, RST_HOUR, 8'h00, 8'h00};
  localparam bcd_byte_t DOW_MAX = BYTE_W'(DOW_LAST);

  logic [FIELD_CNT-1:0][BYTE_W-1:0] nxt;
  logic [BYTE_W:0]                  hr;
  bcd_byte_t                        last_day;
  logic c_sec, c_min, c_day, c_mon, c_yr;

  always_comb begin
    nxt      = live;
    c_sec    = (live[IX_SEC] == 8'h59);
    nxt[IX_SEC] = c_sec ? 8'h00 : bcd_inc(live[IX_SEC]);

    c_min = c_sec && (live[IX_MIN] == 8'h59);
    if (c_sec) nxt[IX_MIN] = (live[IX_MIN] == 8'h59) ? 8'h00 : bcd_inc(live[IX_MIN]);

    hr = hour_inc(live[IX_HOUR]);
    if (c_min) nxt[IX_HOUR] = hr[BYTE_W-1:0];
    c_day = c_min && hr[BYTE_W];

    last_day = month_end(live[IX_MONTH], live[IX_YEAR]);
    c_mon    = c_day && (live[IX_DATE] == last_day);
    if (c_day) begin
      nxt[IX_DATE] = (live[IX_DATE] == last_day) ? 8'h01 : bcd_inc(live[IX_DATE]);
      nxt[IX_DOW]  = (live[IX_DOW] >= DOW_MAX) ? 8'h00 : live[IX_DOW] + 8'h01;
    end

    c_yr = c_mon && (live[IX_MONTH] == 8'h12);
    if (c_mon) nxt[IX_MONTH] = (live[IX_MONTH] == 8'h12) ? 8'h01 : bcd_inc(live[IX_MONTH]);
    if (c_yr)  nxt[IX_YEAR]  = (live[IX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(live[IX_YEAR]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= RST_VALS;
      fail <= 1'b1;
    end else if (load) begin
      for (int i = 0; i < FIELD_CNT; i++) begin
        if (load_mask[i]) begin
          if (i == IX_DOW) live[i] <= {{(BYTE_W-DOW_W){1'b0}}, load_bytes[i][DOW_W-1:0]};
          else             live[i] <= load_bytes[i];
        end
      end
      fail <= 1'b0;
    end else if (tick && !fail) begin
      live <= nxt;
    end
  end

endmodule

// File: rtl/rtc_read_latch.sv
module rtc_read_latch
  import rtc_cal_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             capture,
  input  logic [FIELD_CNT-1:0][BYTE_W-1:0] live,
  input  logic [IDX_W-1:0]                 idx,
  output logic [(1<<IDX_W)-1:0][BYTE_W-1:0] snap_flat,
  output logic [BYTE_W-1:0]                rd_data
);

  localparam int SLOTS = 1 << IDX_W;

  logic [BYTE_W-1:0] snap [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < FIELD_CNT) begin : g_used
      always_ff @(posedge clk) begin
        if (rst)          snap[g] <= '0;
        else if (capture) snap[g] <= live[g];
      end
    end else begin : g_spare
      assign snap[g] = '0;
    end
    assign snap_flat[g] = snap[g];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= snap[idx];
  end

endmodule

// File: rtl/rtc_write_shadow.sv
module rtc_write_shadow
  import rtc_cal_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             sess_open,
  input  logic                             byte_en,
  input  logic [IDX_W-1:0]                 byte_idx,
  input  logic [BYTE_W-1:0]                byte_val,
  input  logic                             sess_close,
  input  logic                             sess_drop,
  output logic                             commit,
  output logic [FIELD_CNT-1:0]             mask,
  output logic [FIELD_CNT-1:0][BYTE_W-1:0] staged
);

  logic                 active;
  logic                 close_q, open_q, put;
  logic [FIELD_CNT-1:0] hit;
  logic [BYTE_W-1:0]    buf_q [FIELD_CNT];

  // priority: drop, close, open, byte
  assign close_q = sess_close && !sess_drop;
  assign open_q  = sess_open && !sess_drop && !sess_close;
  assign put     = byte_en && active && !sess_drop && !sess_close && !sess_open;
  assign commit  = close_q && active && (|mask);

  always_ff @(posedge clk) begin
    if (rst || sess_drop || close_q) active <= 1'b0;
    else if (open_q)                 active <= 1'b1;
  end

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_field
    assign hit[g] = put && (byte_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst || sess_drop || close_q || open_q) mask[g] <= 1'b0;
      else if (hit[g])                           mask[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)         buf_q[g] <= '0;
      else if (hit[g]) buf_q[g] <= byte_val;
    end

    assign staged[g] = buf_q[g];
  end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_cal_pkg::*;
#(
  parameter int        IDX_W     = 3,
  parameter int        DOW_W     = 3,
  parameter int        DOW_LAST  = 6,
  parameter bcd_byte_t RST_HOUR  = 8'h12,
  parameter bcd_byte_t RST_DATE  = 8'h01,
  parameter bcd_byte_t RST_MONTH = 8'h01,
  parameter bcd_byte_t RST_YEAR  = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              rd_start,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              wr_start,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_stop,
  input  logic              wr_abort,
  output logic              clk_fail
);

  localparam int SLOTS = 1 << IDX_W;

  logic                             commit_w;
  logic [FIELD_CNT-1:0]             mask_w;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] staged_w;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] live_w;
  logic [SLOTS-1:0][BYTE_W-1:0]     snap_w;

  rtc_write_shadow #(.IDX_W(IDX_W)) shadow_i (
    .clk        (clk),
    .rst        (rst),
    .sess_open  (wr_start),
    .byte_en    (wr_en),
    .byte_idx   (wr_idx),
    .byte_val   (wr_data),
    .sess_close (wr_stop),
    .sess_drop  (wr_abort),
    .commit     (commit_w),
    .mask       (mask_w),
    .staged     (staged_w)
  );

  rtc_time_counter #(
    .DOW_W     (DOW_W),
    .DOW_LAST  (DOW_LAST),
    .RST_HOUR  (RST_HOUR),
    .RST_DATE  (RST_DATE),
    .RST_MONTH (RST_MONTH),
    .RST_YEAR  (RST_YEAR)
  ) counter_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_1hz),
    .load       (commit_w),
    .load_mask  (mask_w),
    .load_bytes (staged_w),
    .live       (live_w),
    .fail       (clk_fail)
  );

  rtc_read_latch #(.IDX_W(IDX_W)) latch_i (
    .clk       (clk),
    .rst       (rst),
    .capture   (rd_start),
    .live      (live_w),
    .idx       (rd_idx),
    .snap_flat (snap_w),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
  import rtc_cal_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                tick,
  input logic                                rd_start,
  input logic                                clk_fail,
  input logic                                commit,
  input logic [FIELD_CNT-1:0]                mask,
  input logic [FIELD_CNT-1:0][BYTE_W-1:0]    staged,
  input logic [FIELD_CNT-1:0][BYTE_W-1:0]    live,
  input logic [(1<<IDX_W)-1:0][BYTE_W-1:0]   snap
);

  assert_frozen_while_failed_R1: assert property (@(posedge clk) disable iff (rst)
    clk_fail && !commit |=> $stable(live));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !commit && !tick |=> $stable(live));

  assert_sec_rollover_R2: assert property (@(posedge clk) disable iff (rst)
    tick && !clk_fail && !commit && (live[IX_SEC] == 8'h59) |=> live[IX_SEC] == 8'h00);

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_start |=> $stable(snap));

  assert_snap_capture_R8: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> snap[IX_SEC] == $past(live[IX_SEC]));

  assert_commit_wins_R11: assert property (@(posedge clk) disable iff (rst)
    commit && mask[IX_SEC] |=> live[IX_SEC] == $past(staged[IX_SEC]));

  assert_fail_clear_R12: assert property (@(posedge clk) disable iff (rst)
    commit |=> !clk_fail);

  assert_fail_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    !clk_fail |=> !clk_fail);

endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.IDX_W(IDX_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick_1hz),
  .rd_start (rd_start),
  .clk_fail (clk_fail),
  .commit   (commit_w),
  .mask     (mask_w),
  .staged   (staged_w),
  .live     (live_w),
  .snap     (snap_w)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       rd_start = 1'b0;
  logic [2:0] rd_idx = 3'd0;
  logic [7:0] rd_data;
  logic       wr_start = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_stop = 1'b0;
  logic       wr_abort = 1'b0;
  logic       clk_fail;

  always #4 clk = ~clk;

  bcd_rtc_core dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
    .rd_start(rd_start), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_start(wr_start), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_stop(wr_stop), .wr_abort(wr_abort), .clk_fail(clk_fail)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // ---------------- behavioural reference model ----------------
  int m_live [7];
  int m_snap [7];
  int m_buf  [7];
  int m_mask;
  bit m_act;
  bit m_fail;
  int m_rd;
  bit m_started = 1'b0;

  function automatic int step_bcd(int v, int w);
    int lo = v % 16;
    int hi = v / 16;
    if (lo == 9) begin lo = 0; hi = hi + 1; end
    else lo = (lo + 1) % 16;
    return (hi * 16 + lo) % (1 << w);
  endfunction

  function automatic int days_in(int mon, int yr);
    int ybin = (yr / 16) * 10 + (yr % 16);
    if (mon == 'h02) return (ybin % 4 == 0) ? 'h29 : 'h28;
    if (mon == 'h04 || mon == 'h06 || mon == 'h09 || mon == 'h11) return 'h30;
    return 'h31;
  endfunction

  task automatic model_advance();
    bit cy;
    int h, v, pm, last;
    if (m_live[0] != 'h59) begin m_live[0] = step_bcd(m_live[0], 8); return; end
    m_live[0] = 0;
    if (m_live[1] != 'h59) begin m_live[1] = step_bcd(m_live[1], 8); return; end
    m_live[1] = 0;
    h = m_live[2]; cy = 0;
    if (h & 'h80) begin
      v = h & 'h3F;
      if (v == 'h23) begin v = 0; cy = 1; end else v = step_bcd(v, 6);
      h = (h & 'hC0) | v;
    end else begin
      v = h & 'h1F; pm = (h >> 5) & 1;
      if (v == 'h12) v = 1;
      else if (v == 'h11) begin v = 'h12; cy = pm[0]; pm = pm ^ 1; end
      else v = step_bcd(v, 5);
      h = (h & 'hC0) | (pm << 5) | v;
    end
    m_live[2] = h;
    if (!cy) return;
    m_live[6] = (m_live[6] >= 6) ? 0 : m_live[6] + 1;
    last = days_in(m_live[4], m_live[5]);
    if (m_live[3] != last) begin m_live[3] = step_bcd(m_live[3], 8); return; end
    m_live[3] = 1;
    if (m_live[4] != 'h12) begin m_live[4] = step_bcd(m_live[4], 8); return; end
    m_live[4] = 1;
    m_live[5] = (m_live[5] == 'h99) ? 0 : step_bcd(m_live[5], 8);
  endtask

  always @(posedge clk) begin
    int rd_next;
    bit commit;
    if (rst) begin
      m_live = '{0, 0, 'h12, 1, 1, 0, 0};
      m_snap = '{0, 0, 0, 0, 0, 0, 0};
      m_buf  = '{0, 0, 0, 0, 0, 0, 0};
      m_mask = 0; m_act = 0; m_fail = 1; m_rd = 0;
    end else begin
      rd_next = (rd_idx < 7) ? m_snap[rd_idx] : 0;
      if (rd_start) m_snap = m_live;
      commit = 0;
      if (wr_abort) begin m_act = 0; m_mask = 0; end
      else if (wr_stop) begin commit = m_act && (m_mask != 0); m_act = 0; end
      else if (wr_start) begin m_act = 1; m_mask = 0; end
      else if (wr_en && m_act && wr_idx < 7) begin
        m_buf[wr_idx] = wr_data;
        m_mask = m_mask | (1 << wr_idx);
      end
      if (commit) begin
        for (int i = 0; i < 7; i++)
          if (m_mask[i]) m_live[i] = (i == 6) ? (m_buf[i] & 7) : m_buf[i];
        m_fail = 0;
      end else if (tick_1hz && !m_fail) begin
        model_advance();
      end
      if (wr_stop && !wr_abort) m_mask = 0;
      m_rd = rd_next;
    end
    m_started = 1'b1;
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_started && !rst && !done) begin
      n_cmp++;
      if (rd_data !== 8'(m_rd)) begin
        n_bad++;
        $display("FAIL R8 model rd_data actual=%h expected=%h", rd_data, 8'(m_rd));
      end
      n_cmp++;
      if (clk_fail !== m_fail) begin
        n_bad++;
        $display("FAIL R12 model clk_fail actual=%0d expected=%0d", clk_fail, m_fail);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      tick_1hz = 1'b1; @(negedge clk);
      tick_1hz = 1'b0; @(negedge clk);
    end
  endtask

  task automatic freeze();
    rd_start = 1'b1; @(negedge clk);
    rd_start = 1'b0;
  endtask

  task automatic read_chk(int idx, logic [7:0] exp, string tag);
    rd_idx = 3'(idx); @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  task automatic wr_open();
    wr_start = 1'b1; @(negedge clk);
    wr_start = 1'b0;
  endtask

  task automatic wr_put(int idx, logic [7:0] val);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = val; @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_close();
    wr_stop = 1'b1; @(negedge clk);
    wr_stop = 1'b0;
  endtask

  task automatic set_clock(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr_open(); wr_put(2, h); wr_put(1, m); wr_put(0, s); wr_close();
  endtask

  task automatic set_day(logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    wr_open(); wr_put(3, d); wr_put(4, mo); wr_put(5, y); wr_close();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values and fail flag
    check("R1 clk_fail after reset", {7'd0, clk_fail}, 8'h01);
    freeze();
    read_chk(0, 8'h00, "R1 sec"); read_chk(1, 8'h00, "R1 min");
    read_chk(2, 8'h12, "R1 hour"); read_chk(3, 8'h01, "R1 date");
    read_chk(4, 8'h01, "R1 month"); read_chk(5, 8'h00, "R1 year");
    read_chk(6, 8'h00, "R1 dow"); read_chk(7, 8'h00, "R8 spare index");

    // R1: ticks ignored while failed
    do_tick(3); freeze();
    read_chk(0, 8'h00, "R1 frozen sec");

    // R12, R9: single byte commit
    wr_open(); wr_put(0, 8'h58); wr_close();
    check("R12 clk_fail cleared", {7'd0, clk_fail}, 8'h00);
    freeze();
    read_chk(0, 8'h58, "R9 staged sec"); read_chk(1, 8'h00, "R9 untouched min");

    // R2: seconds into minutes
    do_tick(2); freeze();
    read_chk(0, 8'h00, "R2 sec wrap"); read_chk(1, 8'h01, "R2 min carry");

    // R3, R5, R6: full rollover of everything in 24-hour mode
    set_clock(8'hA3, 8'h59, 8'h59); set_day(8'h31, 8'h12, 8'h99);
    wr_open(); wr_put(6, 8'h06); wr_close();
    do_tick(1); freeze();
    read_chk(2, 8'h80, "R3 hour 23 to 00"); read_chk(3, 8'h01, "R6 date wrap");
    read_chk(4, 8'h01, "R6 month wrap"); read_chk(5, 8'h00, "R6 year wrap");
    read_chk(6, 8'h00, "R5 dow wrap");

    // R4: 12-hour format
    set_clock(8'h11, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(2, 8'h32, "R4 11AM to 12PM"); read_chk(3, 8'h01, "R4 no day carry at noon");
    set_clock(8'h31, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(2, 8'h12, "R4 11PM to 12AM"); read_chk(3, 8'h02, "R4 day carry");
    read_chk(6, 8'h01, "R5 dow step");
    set_clock(8'h12, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(2, 8'h01, "R4 12 to 01");

    // R7: leap years
    set_day(8'h28, 8'h02, 8'h24); set_clock(8'hA3, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(3, 8'h29, "R7 leap feb29"); read_chk(4, 8'h02, "R7 leap month");
    set_clock(8'hA3, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(3, 8'h01, "R7 leap mar1"); read_chk(4, 8'h03, "R7 leap march");
    set_day(8'h28, 8'h02, 8'h23); set_clock(8'hA3, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(3, 8'h01, "R7 common mar1"); read_chk(4, 8'h03, "R7 common march");
    set_day(8'h28, 8'h02, 8'h00); set_clock(8'hA3, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(3, 8'h29, "R7 year00 feb29");

    // R6: month lengths
    set_day(8'h30, 8'h04, 8'h10); set_clock(8'hA3, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(3, 8'h01, "R6 april end"); read_chk(4, 8'h05, "R6 to may");
    set_day(8'h30, 8'h11, 8'h10); set_clock(8'hA3, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(4, 8'h12, "R6 november end");
    set_day(8'h30, 8'h01, 8'h10); set_clock(8'hA3, 8'h59, 8'h59); do_tick(1); freeze();
    read_chk(3, 8'h31, "R6 january 31"); read_chk(4, 8'h01, "R6 january stays");

    // R8: frozen copy ignores ticks until the next capture
    wr_open(); wr_put(0, 8'h10); wr_close();
    freeze(); do_tick(3);
    read_chk(0, 8'h10, "R8 frozen copy");
    freeze();
    read_chk(0, 8'h13, "R8 recapture");

    // R10: aborted, empty and sessionless writes
    wr_open(); wr_put(0, 8'h40);
    wr_abort = 1'b1; @(negedge clk); wr_abort = 1'b0;
    wr_close();
    wr_put(0, 8'h44);
    wr_open(); wr_close();
    freeze();
    read_chk(0, 8'h13, "R10 no change");

    // R11: tick on the commit cycle is dropped
    wr_open(); wr_put(0, 8'h30);
    wr_stop = 1'b1; tick_1hz = 1'b1; @(negedge clk);
    wr_stop = 1'b0; tick_1hz = 1'b0;
    freeze();
    read_chk(0, 8'h30, "R11 commit wins");
    do_tick(1); freeze();
    read_chk(0, 8'h31, "R11 next tick");

    // R13: out-of-range value stored and stepped blindly
    wr_open(); wr_put(0, 8'h7A); wr_close();
    freeze();
    read_chk(0, 8'h7A, "R13 stored");
    do_tick(1); freeze();
    read_chk(0, 8'h7B, "R13 stepped");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule